// File: doc/BRIEF.md
# Masked Interrupt Flag and Enable Unit

This unit gathers seven single-cycle interrupt events from neighbouring peripheral logic into a pending-flag register. A second register holds one enable bit per source. The unit pulls a shared active-low interrupt request line low whenever at least one pending flag is also enabled.

Software reaches both registers through a byte-wide register port with a 4-bit select. A flag is acknowledged by writing 1 to its bit. The enable register is never written as a whole value. The top data bit of a write chooses between setting and clearing, and the low seven bits choose which enables change. The top bit of the flag register is not stored. It reads back as the live "interrupt pending" summary.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset all seven flags and all seven enables are 0, `irq_no` is 1, and a read at select 0xD returns 0x00.
- R2: A 1 on `src_set_i[k]` at a clock edge sets flag bit k from that edge on. The bit-to-source order is: bit 6 first timer, bit 5 second timer, bit 4 port B control input 1, bit 3 port B control line 2, bit 2 serial shifter, bit 1 port A control input 1, bit 0 port A control line 2.
- R3: A write to select 0xD clears each flag bit 0..6 whose data bit is 1. Flags whose data bit is 0 keep their value, and data bit 7 has no effect.
- R4: When a set pulse and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R5: A write to select 0xE with data bit 7 = 1 sets each enable bit whose data bit is 1. The other enables are left unchanged.
- R6: A write to select 0xE with data bit 7 = 0 clears each enable bit whose data bit is 1. The other enables are left unchanged.
- R7: A read at select 0xE returns bit 7 = 1 and bits 6..0 = the current enables.
- R8: A read at select 0xD returns bits 6..0 = the flags. Bit 7 is 1 exactly when some flag is set and its enable is also set.
- R9: `irq_no` is low exactly when some enabled flag is set. It first goes low in the cycle after the edge that sets an enabled flag, and it goes high in the cycle after the last enabled flag is cleared or disabled.
- R10: Writes to any select other than 0xD and 0xE change neither flags nor enables. Reads at those selects return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 7 | Per-source set pulses, bit k sets flag k |
| sel_i | input | 4 | Register select |
| we_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current select (combinational) |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
On every cycle, the checker relates each set pulse, flag write and enable write to the register state one edge later. It also ties `irq_no` and the read-back summary bit to the registered flags and enables. Only the bench's scenarios show the externally visible sequences. These are the exact read values after sweeping all 128 source patterns against varying enable masks, the one-cycle latency of the request line, the set-over-clear collision, and the lack of effect of writes to unrelated selects.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int N_SRC  = 7;
  localparam int DATA_W = N_SRC + 1;
  localparam int SEL_W  = 4;
  localparam logic [SEL_W-1:0] FLAG_SEL = 4'hD;
  localparam logic [SEL_W-1:0] EN_SEL   = 4'hE;

  typedef enum int {
    SRC_PA_CTL2 = 0,
    SRC_PA_CTL1 = 1,
    SRC_SHIFT   = 2,
    SRC_PB_CTL2 = 3,
    SRC_PB_CTL1 = 4,
    SRC_TMR2    = 5,
    SRC_TMR1    = 6
  } src_idx_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flag_q[k] <= 1'b0;
      else if (set_i[k])                flag_q[k] <= 1'b1;  // set beats clear
      else if (clr_we_i && clr_mask_i[k]) flag_q[k] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N:0]   wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;
  logic         mode_set;
  logic [N-1:0] mask;

  assign mode_set = wdata_i[N];
  assign mask     = wdata_i[N-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (we_i) begin
      if (mode_set)    en_q <= en_q | mask;
      else             en_q <= en_q & ~mask;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int N     = 7,
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] FLAG_SEL = 4'hD,
  parameter logic [SEL_W-1:0] EN_SEL   = 4'hE
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N-1:0]     flag_i,
  input  logic [N-1:0]     en_i,
  input  logic             pend_i,
  output logic [N:0]       rdata_o
);
  always_comb begin
    if (sel_i == FLAG_SEL)    rdata_o = {pend_i, flag_i};
    else if (sel_i == EN_SEL) rdata_o = {1'b1, en_i};
    else                      rdata_o = '0;
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_set_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  logic [N_SRC-1:0] flag_w;
  logic [N_SRC-1:0] en_w;
  logic             pend_w;
  logic             flag_we;
  logic             en_we;

  assign flag_we = we_i && (sel_i == FLAG_SEL);
  assign en_we   = we_i && (sel_i == EN_SEL);

  irq_flag_reg #(.N(N_SRC)) u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (src_set_i),
    .clr_we_i   (flag_we),
    .clr_mask_i (wdata_i[N_SRC-1:0]),
    .flag_o     (flag_w)
  );

  irq_enable_reg #(.N(N_SRC)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we),
    .wdata_i (wdata_i),
    .en_o    (en_w)
  );

  assign pend_w = |(flag_w & en_w);
  assign irq_no = ~pend_w;

  irq_read_mux #(
    .N(N_SRC), .SEL_W(SEL_W), .FLAG_SEL(FLAG_SEL), .EN_SEL(EN_SEL)
  ) u_rd (
    .sel_i   (sel_i),
    .flag_i  (flag_w),
    .en_i    (en_w),
    .pend_i  (pend_w),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk
  import irq_mask_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_set_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_no,
  input logic [N_SRC-1:0]  flag_w,
  input logic [N_SRC-1:0]  en_w
);
  logic fl_wr, en_wr;
  assign fl_wr = we_i && sel_i == FLAG_SEL;
  assign en_wr = we_i && sel_i == EN_SEL;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |src_set_i |=> ((flag_w & $past(src_set_i)) == $past(src_set_i)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr |=> ((flag_w & $past(wdata_i[N_SRC-1:0]) & ~$past(src_set_i)) == '0));

  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_wr && src_set_i == '0) |=> $stable(flag_w));

  p_en_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr && wdata_i[DATA_W-1]) |=>
      ((en_w & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0])));

  p_en_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr && !wdata_i[DATA_W-1]) |=> ((en_w & $past(wdata_i[N_SRC-1:0])) == '0));

  p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr |=> $stable(en_w));

  p_en_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EN_SEL) |-> (rdata_o == {1'b1, en_w}));

  p_summary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == FLAG_SEL) |-> (rdata_o[DATA_W-1] == !irq_no));

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == ((flag_w & en_w) == '0));
endmodule

bind irq_mask_unit irq_mask_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_set_i (src_set_i),
  .sel_i     (sel_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_no    (irq_no),
  .flag_w    (flag_w),
  .en_w      (en_w)
);

// File: tb/irq_mask_unit_test.sv
module irq_mask_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] src_set_i = '0;
  logic [3:0] sel_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_no;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  irq_mask_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_set_i(src_set_i), .sel_i(sel_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk_i);
    sel_i = s; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    sel_i = s;
    #0.5;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [6:0] p);
    @(negedge clk_i);
    src_set_i = p;
    @(negedge clk_i);
    src_set_i = '0;
  endtask

  function automatic logic [7:0] exp_flag(input logic [6:0] f, input logic [6:0] e);
    return {|(f & e), f};
  endfunction

  initial begin
    #150000;
    total++; bad++;
    $display("FAIL watchdog act=00 exp=01");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [6:0] e, c, m, en_model;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1
    rd(4'hD, v); chk("R1 flags", v, 8'h00);
    rd(4'hE, v); chk("R1 enables", v, 8'h80);
    chk("R1 irq", {7'd0, irq_no}, 8'h01);

    // R2 single-source mapping, first timer at bit 6, port A line 2 at bit 0
    pulse(7'h40); rd(4'hD, v); chk("R2 tmr1 bit6", v, 8'h40);
    wr(4'hD, 8'h7F);
    pulse(7'h01); rd(4'hD, v); chk("R2 ca2 bit0", v, 8'h01);
    wr(4'hD, 8'h7F);

    for (int p = 0; p < 128; p++) begin
      e = 7'((p * 37 + 11) & 8'h7F);
      c = 7'((p * 53) & 8'h7F);
      m = 7'((p * 29 + 5) & 8'h7F);
      wr(4'hD, 8'h7F);
      wr(4'hE, 8'h7F);
      wr(4'hE, {1'b1, e});
      en_model = e;
      rd(4'hE, v); chk("R5 set enables", v, {1'b1, en_model});
      // drive set pulse, irq must still be high before the edge (R9)
      @(negedge clk_i);
      src_set_i = 7'(p);
      #0.5;
      chk("R9 irq before edge", {7'd0, irq_no}, 8'h01);
      @(negedge clk_i);
      src_set_i = '0;
      rd(4'hD, v); chk("R2/R8 flags+summary", v, exp_flag(7'(p), e));
      chk("R9 irq after edge", {7'd0, irq_no}, {7'd0, ~|(7'(p) & e)});
      // bit 7 of a flag write has no effect
      wr(4'hD, 8'h80);
      rd(4'hD, v); chk("R3 bit7 ignored", v, exp_flag(7'(p), e));
      // partial clear
      wr(4'hD, {1'b0, c});
      rd(4'hD, v); chk("R3 partial clear", v, exp_flag(7'(p) & ~c, en_model));
      chk("R9 irq after clear", {7'd0, irq_no}, {7'd0, ~|(7'(p) & ~c & en_model)});
      // enable clear write
      wr(4'hE, {1'b0, m});
      en_model = en_model & ~m;
      rd(4'hE, v); chk("R6 clear enables", v, {1'b1, en_model});
      rd(4'hD, v); chk("R8 summary after disable", v, exp_flag(7'(p) & ~c, en_model));
      // further set keeps others
      wr(4'hE, {1'b1, m & 7'h15});
      en_model = en_model | (m & 7'h15);
      rd(4'hE, v); chk("R5 set keeps others", v, {1'b1, en_model});
    end

    // R4 collision: set and clear the same bits in one cycle
    wr(4'hD, 8'h7F);
    wr(4'hE, 8'hFF);
    @(negedge clk_i);
    src_set_i = 7'h2A; sel_i = 4'hD; wdata_i = 8'hFF; we_i = 1'b1;
    @(negedge clk_i);
    src_set_i = '0; we_i = 1'b0; wdata_i = '0;
    rd(4'hD, v); chk("R4 set wins", v, 8'hAA);

    // R9 release when last enabled flag is disabled, then cleared
    wr(4'hE, 8'h7F);
    chk("R9 irq high after disable", {7'd0, irq_no}, 8'h01);
    wr(4'hE, 8'h82);
    chk("R9 irq low after enable", {7'd0, irq_no}, 8'h00);
    wr(4'hD, 8'h02);
    chk("R9 irq high after ack", {7'd0, irq_no}, 8'h01);
    rd(4'hD, v); chk("R3 others kept", v, 8'h28);

    // R10 other selects
    for (int s = 0; s < 16; s++) begin
      if (s == 13 || s == 14) continue;
      wr(4'(s), 8'hFF);
      wr(4'(s), 8'h7F);
      rd(4'(s), v); chk("R10 read other", v, 8'h00);
      rd(4'hD, v); chk("R10 flags kept", v, 8'h28);
      rd(4'hE, v); chk("R10 enables kept", v, 8'h82);
    end

    // R1 reset mid-run
    wr(4'hE, 8'hFF);
    pulse(7'h7F);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    rd(4'hD, v); chk("R1 reset flags", v, 8'h00);
    rd(4'hE, v); chk("R1 reset enables", v, 8'h80);
    chk("R1 reset irq", {7'd0, irq_no}, 8'h01);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule